// File: doc/BRIEF.md
# Data-Strobe Serial Line Encoder

This block takes bytes from a parallel producer and sends them over a two-wire link made of a data line and a strobe line. It sends one bit each time the bit-period enable is high. Each byte goes out least significant bit first. No clock travels with the data. Instead, the strobe line toggles whenever a new bit has the same value as the bit before it. As a result, exactly one of the two wires changes at every bit boundary, and the receiver can rebuild the bit timing from the two wires alone.

The producer offers a byte with `in_valid`. The encoder takes the byte on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is only raised in a bit period, and only when the serializer is empty or is sending the last bit of the current byte. This lets a stream of bytes run with no gap between them, and the strobe rule carries on unbroken across each byte boundary. When no byte follows, the data line goes back to its idle high level and both lines stay quiet. `busy` marks the bit periods that carry a byte.

Top module: `dse_encoder`

## Requirements
- R1: While reset is asserted, and right after it is released, `ds_data` is 1, `ds_strobe` is 1, `busy` is 0 and `in_ready` is 0 when `bit_en` is 0.
- R2: A byte taken at an enabled edge appears on `ds_data` with bit 0 first. Bit k is on the line after the (k+1)-th enabled edge, counting the accepting edge as the first, so each bit holds for one bit period.
- R3: At every enabled edge that puts a new bit on the line, `ds_strobe` toggles if the new bit equals the present `ds_data` level and holds otherwise. The first bit after idle is compared with the idle level 1. Data and strobe never change at the same edge.
- R4: `ds_data`, `ds_strobe` and `busy` change only at clock edges where `bit_en` is high.
- R5: `in_ready` is 1 exactly when `bit_en` is 1 and either `busy` is 0 or the last bit of the current byte is on the line. A byte is taken at an edge where `in_valid` and `in_ready` are both 1.
- R6: `in_valid` has no effect while `in_ready` is 0, whether in the middle of a byte or outside a bit period. The lines and `busy` keep to the byte already being sent.
- R7: A byte taken while the last bit of the previous byte is on the line puts its bit 0 on the line at that same edge. No idle period comes between the two bytes, and `busy` stays 1.
- R8: At the enabled edge after a last bit, with no new byte taken, `ds_data` goes to 1, `ds_strobe` holds and `busy` falls. While idle, neither line changes.
- R9: `busy` is 1 from the accepting edge through the bit period of the eighth bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One-cycle pulse that marks each bit period |
| in_data | input | 8 | Byte offered by the producer |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | The encoder takes the byte at this edge |
| ds_data | output | 1 | Serial data line level |
| ds_strobe | output | 1 | Strobe line level |
| busy | output | 1 | A byte's bit is on the line |

## Verification
All three outputs come from registers that move only at enabled edges. Each line result is therefore due right after the enabled edge that takes the byte or shifts the next bit. The bench samples them on the following falling edge. `in_ready` is combinational from `bit_en` and the serializer state, so it is sampled 1 ns after `bit_en` is driven and before the edge that uses it. Between enabled edges the bench waits two clocks with the enable low and checks that the lines, `busy` and `in_ready` have not moved, even while `in_valid` is still held high.

// File: rtl/dse_pkg.sv
package dse_pkg;

   // Order in which the bits of a word leave the serializer
   typedef enum logic {
      ORDER_LSB = 1'b0,
      ORDER_MSB = 1'b1
   } dse_order_e;

   // Strobe level after a bit is sent: toggle when the data line would not move
   function automatic logic dse_strobe_next(input logic cur_data,
                                            input logic new_bit,
                                            input logic cur_strobe);
      return cur_strobe ^ (cur_data ~^ new_bit);
   endfunction

endpackage

// File: rtl/dse_shifter.sv
module dse_shifter
   import dse_pkg::*;
#(
   parameter int unsigned WORD_W = 8,
   parameter dse_order_e  ORDER  = ORDER_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [WORD_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              busy,
   output logic              bit_go,
   output logic              bit_val,
   output logic              idle_go
);

   localparam int unsigned    CNT_W    = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

   logic [WORD_W-1:0] shreg_q;
   logic [WORD_W-1:0] load_word;
   logic [WORD_W-1:0] shift_word;
   logic [CNT_W-1:0]  cnt_q;
   logic              busy_q;
   logic              first_bit;
   logic              head_bit;
   logic              on_last;
   logic              accept;

   // Pick the bit order; the register keeps the bits still to be sent
   generate
      if (ORDER == ORDER_LSB) begin : g_lsb
         assign first_bit  = in_data[0];
         assign head_bit   = shreg_q[0];
         assign load_word  = {1'b0, in_data[WORD_W-1:1]};
         assign shift_word = {1'b0, shreg_q[WORD_W-1:1]};
      end else begin : g_msb
         assign first_bit  = in_data[WORD_W-1];
         assign head_bit   = shreg_q[WORD_W-1];
         assign load_word  = {in_data[WORD_W-2:0], 1'b0};
         assign shift_word = {shreg_q[WORD_W-2:0], 1'b0};
      end
   endgenerate

   assign on_last  = busy_q && (cnt_q == LAST_IDX);
   assign in_ready = bit_en && (!busy_q || on_last);
   assign accept   = in_valid && in_ready;
   assign bit_go   = accept || (bit_en && busy_q && !on_last);
   assign bit_val  = accept ? first_bit : head_bit;
   assign idle_go  = bit_en && on_last && !accept;
   assign busy     = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         cnt_q   <= '0;
         busy_q  <= 1'b0;
      end else if (accept) begin
         shreg_q <= load_word;
         cnt_q   <= '0;
         busy_q  <= 1'b1;
      end else if (bit_go) begin
         shreg_q <= shift_word;
         cnt_q   <= cnt_q + 1'b1;
      end else if (idle_go) begin
         cnt_q   <= '0;
         busy_q  <= 1'b0;
      end
   end

endmodule

// File: rtl/dse_line_coder.sv
module dse_line_coder
   import dse_pkg::*;
#(
   parameter logic IDLE_LEVEL   = 1'b1,
   parameter logic RESET_STROBE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_go,
   input  logic bit_val,
   input  logic idle_go,
   output logic line_data,
   output logic line_strobe
);

   logic data_q;
   logic strobe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q   <= IDLE_LEVEL;
         strobe_q <= RESET_STROBE;
      end else if (bit_go) begin
         data_q   <= bit_val;
         strobe_q <= dse_strobe_next(data_q, bit_val, strobe_q);
      end else if (idle_go) begin
         data_q   <= IDLE_LEVEL;
      end
   end

   assign line_data   = data_q;
   assign line_strobe = strobe_q;

endmodule

// File: rtl/dse_encoder.sv
module dse_encoder
   import dse_pkg::*;
#(
   parameter int unsigned WORD_W       = 8,
   parameter dse_order_e  ORDER        = ORDER_LSB,
   parameter logic        IDLE_LEVEL   = 1'b1,
   parameter logic        RESET_STROBE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [WORD_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              ds_data,
   output logic              ds_strobe,
   output logic              busy
);

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("dse_encoder: WORD_W must be at least 2");
      end
   endgenerate

   logic bit_go;
   logic bit_val;
   logic idle_go;

   dse_shifter #(
      .WORD_W (WORD_W),
      .ORDER  (ORDER)
   ) u_shifter (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .in_data  (in_data),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .busy     (busy),
      .bit_go   (bit_go),
      .bit_val  (bit_val),
      .idle_go  (idle_go)
   );

   dse_line_coder #(
      .IDLE_LEVEL   (IDLE_LEVEL),
      .RESET_STROBE (RESET_STROBE)
   ) u_coder (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_go      (bit_go),
      .bit_val     (bit_val),
      .idle_go     (idle_go),
      .line_data   (ds_data),
      .line_strobe (ds_strobe)
   );

endmodule

// File: rtl/dse_encoder_chk.sv
module dse_encoder_chk #(
   parameter int unsigned WORD_W     = 8,
   parameter logic        IDLE_LEVEL = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic in_valid,
   input logic in_ready,
   input logic ds_data,
   input logic ds_strobe,
   input logic busy
);

   localparam int unsigned RUN_W   = $clog2(WORD_W) + 1;
   localparam logic [RUN_W-1:0] LAST_RUN = RUN_W'(WORD_W - 1);

   logic             take;
   logic [RUN_W-1:0] run_q;

   assign take = bit_en && in_valid && in_ready;

   // Counts the bits of the current byte already placed on the line, minus one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                run_q <= '0;
      else if (take)             run_q <= '0;
      else if (bit_en && busy)   run_q <= run_q + 1'b1;
   end

   a_r3_single_change: assert property (@(posedge clk) disable iff (!rst_n)
      !((ds_data != $past(ds_data)) && (ds_strobe != $past(ds_strobe))));

   a_r4_hold_without_en: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> ($stable(ds_data) && $stable(ds_strobe) && $stable(busy)));

   a_r5_ready_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> bit_en);

   a_r7_chain_busy: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> busy);

   a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ds_data == IDLE_LEVEL));

   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !take) |=> $stable(ds_strobe));

   a_r9_busy_spans_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bit_en && !take && (run_q < LAST_RUN)) |=> busy);

   a_r9_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bit_en && !take && (run_q == LAST_RUN)) |=> !busy);

endmodule

bind dse_encoder dse_encoder_chk #(
   .WORD_W     (WORD_W),
   .IDLE_LEVEL (IDLE_LEVEL)
) u_dse_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_en    (bit_en),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .ds_data   (ds_data),
   .ds_strobe (ds_strobe),
   .busy      (busy)
);

// File: tb/test_dse_encoder.sv
module test_dse_encoder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_ready;
   logic       ds_data;
   logic       ds_strobe;
   logic       busy;

   int checks = 0;
   int errors = 0;

   // Bench model, built from the requirements
   logic       exp_d = 1'b1;
   logic       exp_s = 1'b1;
   logic       m_busy = 1'b0;
   int         m_cnt = 0;
   logic [7:0] m_byte = 8'h00;

   // [11:8] periods without an offer before this byte, [7:0] the byte
   localparam logic [11:0] VEC [10] = '{
      {4'd0,  8'hA5}, {4'd0,  8'h3C}, {4'd9,  8'h80}, {4'd10, 8'h00},
      {4'd0,  8'hFF}, {4'd0,  8'h55}, {4'd12, 8'h7F}, {4'd9,  8'hAA},
      {4'd0,  8'h01}, {4'd0,  8'hFE}
   };

   always #5 clk = ~clk;

   dse_encoder i_dse_encoder (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .in_data   (in_data),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .ds_data   (ds_data),
      .ds_strobe (ds_strobe),
      .busy      (busy)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic emit(input logic b);
      if (b == exp_d) exp_s = ~exp_s;
      exp_d = b;
   endtask

   task automatic check_lines(input string req);
      chk(req, "ds_data", ds_data, exp_d);
      chk(req, "ds_strobe", ds_strobe, exp_s);
      chk("R9", "busy", busy, m_busy);
   endtask

   // One bit period: enable for one clock, then two clocks with the enable low
   task automatic period(input logic offer, input logic [7:0] b, output logic taken);
      logic exp_rdy;
      logic was_busy;
      bit_en   = 1'b1;
      in_valid = offer;
      in_data  = b;
      #1;
      exp_rdy = !m_busy || (m_cnt == 7);
      chk("R5", "in_ready", in_ready, exp_rdy);
      taken    = offer && exp_rdy;
      was_busy = m_busy;
      @(posedge clk);
      @(negedge clk);
      bit_en = 1'b0;
      if (taken) begin
         m_byte = b;
         m_cnt  = 0;
         m_busy = 1'b1;
         emit(b[0]);
      end else if (m_busy && m_cnt < 7) begin
         m_cnt++;
         emit(m_byte[m_cnt]);
      end else if (m_busy) begin
         m_busy = 1'b0;
         exp_d  = 1'b1;
      end
      if (taken && was_busy) check_lines("R7");
      else if (!m_busy)      check_lines("R8");
      else                   check_lines("R3");
      // Valid stays up if the byte was not taken: must have no effect (R6)
      repeat (2) @(negedge clk);
      chk("R5", "in_ready without bit_en", in_ready, 1'b0);
      check_lines(offer && !taken ? "R6" : "R4");
      in_valid = 1'b0;
   endtask

   initial begin
      #1_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish");
      summary();
   end

   initial begin
      logic taken;
      // R1: reset values
      repeat (3) @(negedge clk);
      chk("R1", "ds_data in reset", ds_data, 1'b1);
      chk("R1", "ds_strobe in reset", ds_strobe, 1'b1);
      chk("R1", "busy in reset", busy, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ds_data after reset", ds_data, 1'b1);
      chk("R1", "ds_strobe after reset", ds_strobe, 1'b1);
      chk("R1", "in_ready without bit_en", in_ready, 1'b0);

      // R6: valid held without any bit period is ignored
      in_valid = 1'b1;
      in_data  = 8'h0F;
      repeat (5) @(negedge clk);
      chk("R6", "busy with valid only", busy, 1'b0);
      chk("R6", "ds_data with valid only", ds_data, 1'b1);
      chk("R6", "ds_strobe with valid only", ds_strobe, 1'b1);
      in_valid = 1'b0;

      // Vector table: chained bytes, gaps and idle returns
      foreach (VEC[i]) begin
         for (int g = 0; g < int'(VEC[i][11:8]); g++) period(1'b0, 8'h00, taken);
         taken = 1'b0;
         while (!taken) period(1'b1, VEC[i][7:0], taken);
      end
      for (int g = 0; g < 10; g++) period(1'b0, 8'h00, taken);
      chk("R8", "busy after stream", busy, 1'b0);

      // R1: reset in the middle of a byte returns the lines to their reset levels
      period(1'b1, 8'h00, taken);
      period(1'b0, 8'h00, taken);
      period(1'b0, 8'h00, taken);
      rst_n = 1'b0;
      #1;
      chk("R1", "ds_data mid-byte reset", ds_data, 1'b1);
      chk("R1", "ds_strobe mid-byte reset", ds_strobe, 1'b1);
      chk("R1", "busy mid-byte reset", busy, 1'b0);
      exp_d = 1'b1; exp_s = 1'b1; m_busy = 1'b0; m_cnt = 0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: first bit 1 matches the idle level, so only the strobe moves
      period(1'b1, 8'hFF, taken);
      chk("R3", "strobe toggles on first bit 1", ds_strobe, 1'b0);
      chk("R3", "data holds on first bit 1", ds_data, 1'b1);
      // R2: bits of 0xFF keep data high; strobe toggles each period
      period(1'b0, 8'h00, taken);
      chk("R2", "second bit strobe", ds_strobe, 1'b1);
      for (int g = 0; g < 8; g++) period(1'b0, 8'h00, taken);
      chk("R8", "idle after 0xFF", busy, 1'b0);

      summary();
   end

endmodule